// File: doc/BRIEF.md
# Compare-and-Conditional-Move Execute Unit

This execute-stage unit of a 32-bit RISC core evaluates two instruction families. The first is the set-on-less-than family: signed and unsigned, each with a register operand or an immediate operand. Each of these writes a result of 0 or 1. The second family is the pair of conditional moves. A conditional move copies the first source value to its destination, and whether the register write happens depends on whether the second source value is zero.

The decode stage supplies the primary opcode, the low 16 bits of the instruction word, the rt field and the two source register values. In register-format instructions the low 16 bits hold the destination index in bits [15:11] and the function code in bits [5:0]. In immediate-format instructions the same 16 bits are the immediate.

The unit returns a 32-bit result, a write-enable and a destination index. Operations travel on a valid/ready stream. Each accepted operation lands in a single output register. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds every field steady.

Top module: `cmpmov_unit`

## Requirements
- R1: With opcode 0x00 and function code (imm bits [5:0]) 0x2a, the result is 1 when rs is less than rt as two's-complement numbers, else 0. The destination is imm bits [15:11] and write-enable is 1.
- R2: With opcode 0x00 and function code 0x2b, the result is 1 when rs is less than rt as unsigned numbers, else 0. The destination is imm bits [15:11]. For example, rs=1 and rt=0xffffffff gives 1 here and 0 under R1.
- R3: Opcode 0x0a compares rs, as a signed number, with the 16-bit immediate sign-extended to 32 bits. The destination is the rt index.
- R4: Opcode 0x0b compares rs, as an unsigned number, with the sign-extended immediate, also treated as unsigned. The destination is the rt index.
- R5: Every compare result has bits [31:1] at zero and write-enable at 1.
- R6: Opcode 0x00 with function code 0x0a returns rs as the result with destination imm bits [15:11]. Write-enable is 1 only when rt equals zero.
- R7: Opcode 0x00 with function code 0x0b returns rs as the result with destination imm bits [15:11]. Write-enable is 1 only when rt is nonzero.
- R8: Any other opcode, or opcode 0x00 with any other function code, produces result 0, destination 0 and write-enable 0.
- R9: An accepted operation appears on the output in the cycle right after acceptance. Outputs leave in the order they were accepted.
- R10: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result`, `out_wr_en` and `out_dest` stay unchanged on the next cycle.
- R11: During reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| in_opcode | input | 6 | Primary opcode |
| in_imm | input | 16 | Low instruction half: immediate, or rd/shamt/function |
| in_rt_idx | input | 5 | rt register index |
| in_rs_val | input | 32 | rs register value |
| in_rt_val | input | 32 | rt register value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Compare flag or moved value |
| out_wr_en | output | 1 | Register write permitted |
| out_dest | output | 5 | Destination register index |

## Verification
Every result is due one clock edge after its operation is accepted, so the bench samples the output on the falling edge after that acceptance edge. A queue keeps the expected items in acceptance order. The consumer's ready line is toggled on a fixed pattern, and the output is popped only on falling edges where valid and ready are both high. That means a result held across stall cycles is compared once, at the edge where it actually leaves. On each stalled cycle the bench also checks that the held fields match the previous cycle.

// File: rtl/cmpmov_pkg.sv
package cmpmov_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OPC_W-1:0] OPC_LTI   = 6'h0a;
  localparam logic [OPC_W-1:0] OPC_LTIU  = 6'h0b;
  localparam logic [FN_W-1:0]  FN_LT     = 6'h2a;
  localparam logic [FN_W-1:0]  FN_LTU    = 6'h2b;
  localparam logic [FN_W-1:0]  FN_MOVZ   = 6'h0a;
  localparam logic [FN_W-1:0]  FN_MOVN   = 6'h0b;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_LT,
    KIND_LTU,
    KIND_LTI,
    KIND_LTIU,
    KIND_MOVZ,
    KIND_MOVN
  } op_kind_e;
endpackage

// File: rtl/cmpmov_decode.sv
module cmpmov_decode
  import cmpmov_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output op_kind_e         kind
);
  always_comb begin
    kind = KIND_NONE;
    unique case (opcode)
      OPC_REG: begin
        case (funct)
          FN_LT:   kind = KIND_LT;
          FN_LTU:  kind = KIND_LTU;
          FN_MOVZ: kind = KIND_MOVZ;
          FN_MOVN: kind = KIND_MOVN;
          default: kind = KIND_NONE;
        endcase
      end
      OPC_LTI:  kind = KIND_LTI;
      OPC_LTIU: kind = KIND_LTIU;
      default:  kind = KIND_NONE;
    endcase
  end
endmodule

// File: rtl/cmpmov_compare.sv
module cmpmov_compare #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs_reg,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  input  logic              is_signed,
  output logic              less
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] rhs;
  logic              ult;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    end else begin : g_noext
      assign imm_ext = imm[DATA_W-1:0];
    end
  endgenerate

  assign rhs = use_imm ? imm_ext : rhs_reg;
  assign ult = lhs < rhs;

  // One magnitude comparator serves both orderings; signs differing decides signed case.
  always_comb begin
    if (is_signed && (lhs[DATA_W-1] != rhs[DATA_W-1])) less = lhs[DATA_W-1];
    else                                               less = ult;
  end
endmodule

// File: rtl/cmpmov_outreg.sv
module cmpmov_outreg #(
  parameter int PAY_W = 38
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [PAY_W-1:0] up_data,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [PAY_W-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end
endmodule

// File: rtl/cmpmov_unit.sv
module cmpmov_unit
  import cmpmov_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OPC_W-1:0]  in_opcode,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [IDX_W-1:0]  in_rt_idx,
  input  logic [DATA_W-1:0] in_rs_val,
  input  logic [DATA_W-1:0] in_rt_val,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_wr_en,
  output logic [IDX_W-1:0]  out_dest
);
  localparam int PAY_W  = DATA_W + 1 + IDX_W;
  localparam int RD_LSB = IMM_W - IDX_W;

  op_kind_e          kind;
  logic              less;
  logic              use_imm;
  logic              is_signed;
  logic              rt_zero;
  logic [IDX_W-1:0]  rd_idx;
  logic [DATA_W-1:0] res_d;
  logic              wr_d;
  logic [IDX_W-1:0]  dest_d;

  assign rd_idx    = in_imm[IMM_W-1:RD_LSB];
  assign use_imm   = (kind == KIND_LTI) || (kind == KIND_LTIU);
  assign is_signed = (kind == KIND_LT)  || (kind == KIND_LTI);
  assign rt_zero   = ~|in_rt_val;

  cmpmov_decode u_dec (
    .opcode (in_opcode),
    .funct  (in_imm[FN_W-1:0]),
    .kind   (kind)
  );

  cmpmov_compare #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_cmp (
    .lhs       (in_rs_val),
    .rhs_reg   (in_rt_val),
    .imm       (in_imm),
    .use_imm   (use_imm),
    .is_signed (is_signed),
    .less      (less)
  );

  always_comb begin
    res_d  = '0;
    wr_d   = 1'b0;
    dest_d = '0;
    case (kind)
      KIND_LT, KIND_LTU: begin
        res_d  = {{(DATA_W-1){1'b0}}, less};
        wr_d   = 1'b1;
        dest_d = rd_idx;
      end
      KIND_LTI, KIND_LTIU: begin
        res_d  = {{(DATA_W-1){1'b0}}, less};
        wr_d   = 1'b1;
        dest_d = in_rt_idx;
      end
      KIND_MOVZ: begin
        res_d  = in_rs_val;
        wr_d   = rt_zero;
        dest_d = rd_idx;
      end
      KIND_MOVN: begin
        res_d  = in_rs_val;
        wr_d   = !rt_zero;
        dest_d = rd_idx;
      end
      default: ;
    endcase
  end

  cmpmov_outreg #(.PAY_W(PAY_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  ({res_d, wr_d, dest_d}),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  ({out_result, out_wr_en, out_dest})
  );
endmodule

// File: rtl/cmpmov_unit_chk.sv
module cmpmov_unit_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [5:0]        in_opcode,
  input logic [IMM_W-1:0]  in_imm,
  input logic [IDX_W-1:0]  in_rt_idx,
  input logic [DATA_W-1:0] in_rs_val,
  input logic [DATA_W-1:0] in_rt_val,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_wr_en,
  input logic [IDX_W-1:0]  out_dest
);
  logic take;
  logic is_reg;
  logic [DATA_W-1:0] imm_sx;
  assign take   = in_valid && in_ready;
  assign is_reg = (in_opcode == 6'h00);
  assign imm_sx = {{(DATA_W-IMM_W){in_imm[IMM_W-1]}}, in_imm};

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R11
  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready)); // R10
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_wr_en) && $stable(out_dest))); // R10
  AST_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R9
  AST_IMM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_opcode == 6'h0a || in_opcode == 6'h0b)) |=>
      (out_result[DATA_W-1:1] == '0 && out_wr_en && out_dest == $past(in_rt_idx))); // R5
  AST_IMM_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_opcode == 6'h0a && in_rs_val == imm_sx) |=> (out_result == '0)); // R3
  AST_MOVZ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_reg && in_imm[5:0] == 6'h0a) |=>
      (out_result == $past(in_rs_val) && out_wr_en == ($past(in_rt_val) == '0)
       && out_dest == $past(in_imm[IMM_W-1:IMM_W-IDX_W]))); // R6
  AST_MOVN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_reg && in_imm[5:0] == 6'h0b) |=>
      (out_wr_en == ($past(in_rt_val) != '0))); // R7
  AST_NO_WRITE_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !is_reg && in_opcode != 6'h0a && in_opcode != 6'h0b) |=>
      (!out_wr_en && out_result == '0 && out_dest == '0)); // R8
endmodule

bind cmpmov_unit cmpmov_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) chk_i (.*);

// File: tb/cmpmov_unit_tb_top.sv
module cmpmov_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_opcode = '0;
  logic [15:0] in_imm = '0;
  logic [4:0]  in_rt_idx = '0;
  logic [31:0] in_rs_val = '0;
  logic [31:0] in_rt_val = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_wr_en;
  logic [4:0]  out_dest;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [37:0] expq[$];
  string       tagq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmpmov_unit dut_i (.*);

  function automatic logic [37:0] model(input logic [5:0] op, input logic [15:0] im,
                                        input logic [4:0] rt_i, input logic [31:0] a,
                                        input logic [31:0] b);
    logic [31:0] sx;
    logic [4:0]  rd;
    sx = {{16{im[15]}}, im};
    rd = im[15:11];
    if (op == 6'h0a) return {31'd0, ($signed(a) < $signed(sx)), 1'b1, rt_i};
    if (op == 6'h0b) return {31'd0, (a < sx), 1'b1, rt_i};
    if (op == 6'h00) begin
      case (im[5:0])
        6'h2a: return {31'd0, ($signed(a) < $signed(b)), 1'b1, rd};
        6'h2b: return {31'd0, (a < b), 1'b1, rd};
        6'h0a: return {a, (b == 0), rd};
        6'h0b: return {a, (b != 0), rd};
        default: return 38'd0;
      endcase
    end
    return 38'd0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [37:0] act, input logic [37:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at a falling edge.
  task automatic send(input string tag, input logic [5:0] op, input logic [15:0] im,
                      input logic [4:0] rt_i, input logic [31:0] a, input logic [31:0] b);
    in_opcode = op; in_imm = im; in_rt_idx = rt_i; in_rs_val = a; in_rt_val = b;
    in_valid = 1'b1;
    expq.push_back(model(op, im, rt_i, a, b));
    tagq.push_back(tag);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R9 result due next cycle", {37'd0, out_valid}, 38'd1);
  endtask

  // Consumer ready pattern, changed just after each rising edge.
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      out_ready = (cyc % 3) != 0;
    end
  end

  // Monitor / scoreboard.
  initial begin
    bit          held = 0;
    logic [37:0] last = '0;
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        if (held)
          check(out_valid && ({out_result, out_wr_en, out_dest} == last),
                "R10 hold while stalled", {out_result, out_wr_en, out_dest}, last);
        check(in_ready == (!out_valid || out_ready), "R10 ready rule",
              {37'd0, in_ready}, {37'd0, (!out_valid || out_ready)});
        if (out_valid && out_ready) begin
          if (expq.size() == 0) begin
            check(1'b0, "R9 unexpected output", {out_result, out_wr_en, out_dest}, 38'd0);
          end else begin
            logic [37:0] e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            check({out_result, out_wr_en, out_dest} == e, t, {out_result, out_wr_en, out_dest}, e);
          end
        end
        held = out_valid && !out_ready;
        last = {out_result, out_wr_en, out_dest};
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R11 reset state",
          {36'd0, out_valid, in_ready}, 38'd1);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R2: 1 vs 0xffffffff differ by signedness; rd = 5 in imm[15:11]
    send("R1 signed reg lt", 6'h00, {5'd5, 5'd0, 6'h2a}, 5'd9, 32'd1, 32'hffffffff);
    send("R2 unsigned reg lt", 6'h00, {5'd5, 5'd0, 6'h2b}, 5'd9, 32'd1, 32'hffffffff);
    send("R1 signed neg lt pos", 6'h00, {5'd7, 5'd0, 6'h2a}, 5'd2, 32'h80000000, 32'd3);
    send("R2 unsigned equal", 6'h00, {5'd31, 5'd0, 6'h2b}, 5'd2, 32'd44, 32'd44);
    // R3 / R4: immediate sign-extended, dest = rt index
    send("R3 signed imm -1", 6'h0a, 16'hffff, 5'd12, 32'h80000000, 32'd0);
    send("R3 signed imm max", 6'h0a, 16'h7fff, 5'd13, 32'd5, 32'd0);
    send("R3 signed imm equal", 6'h0a, 16'h8000, 5'd14, 32'hffff8000, 32'd0);
    send("R4 unsigned ext imm", 6'h0b, 16'hffff, 5'd15, 32'd5, 32'd0);
    send("R4 unsigned top", 6'h0b, 16'hffff, 5'd16, 32'hffffffff, 32'd0);
    send("R5 upper bits zero", 6'h0b, 16'h0001, 5'd17, 32'd0, 32'hdeadbeef);
    // R6 / R7: moves
    send("R6 movz rt zero", 6'h00, {5'd3, 5'd0, 6'h0a}, 5'd1, 32'hcafef00d, 32'd0);
    send("R6 movz rt nonzero", 6'h00, {5'd3, 5'd0, 6'h0a}, 5'd1, 32'hcafef00d, 32'd1);
    send("R7 movn rt zero", 6'h00, {5'd4, 5'd0, 6'h0b}, 5'd1, 32'h12345678, 32'd0);
    send("R7 movn rt msb", 6'h00, {5'd4, 5'd0, 6'h0b}, 5'd1, 32'h12345678, 32'h80000000);
    // R8: unsupported encodings
    send("R8 other funct", 6'h00, {5'd6, 5'd0, 6'h20}, 5'd1, 32'd1, 32'd2);
    send("R8 other opcode", 6'h04, 16'h2a2a, 5'd8, 32'd1, 32'd2);
    send("R8 imm-like opcode", 6'h0c, 16'h000b, 5'd8, 32'd0, 32'd0);
    while (expq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule